// File: doc/BRIEF.md
# Decimation clock and incremental gate selector

This block derives two shared control signals from a bus of sixteen digital block outputs. One is the external decimation clock, taken from one of the first twelve lines of the bus. The other is an incremental gating signal, taken from any of the sixteen lines. Both choices are held in select fields that software loads through two narrow control register writes. Each write strobe carries half of every field.

The gating signal is sent to six analog columns, and each column has its own gate enable. Each column applies a 4-bit truth table to its own comparator bit and the comparator bit of its neighbour. Early-gate columns gate the comparator bit before the truth table. Late-gate columns gate the truth-table result. The outputs downstream see the gated column results, the decimation clock and the gate signal, and all of them are registered.

The decimation clock is suppressed while an internal decimation rate is programmed. Select codes that point past the twelve valid decimation candidates give a constant low clock.

Top module: `dgs_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dclk_out`, `gate_out` and `col_out` are 0. Reset clears both select fields to code 0.
- R2: With `dec_rate` equal to 0 and a decimation select code s from 0 to 11, `dclk_out` equals `blk_out[s]` as sampled one clock edge earlier.
- R3: Decimation select codes 12 to 15 hold `dclk_out` low for every `blk_out` value.
- R4: Any nonzero `dec_rate` holds `dclk_out` low whatever the decimation select code is.
- R5: For a gate select code g from 0 to 15, `gate_out` equals `blk_out[g]` as sampled one edge earlier.
- R6: `cfg_wr_a` loads `cfg_wdata[1:0]` into decimation select bits [1:0] and `cfg_wdata[3:2]` into gate select bits [1:0]. `cfg_wr_b` loads the same `cfg_wdata` positions into bits [3:2] of the two fields. The half that is not written keeps its value.
- R7: A select write lands on the clock edge of the write cycle. The registered outputs reflect the new code starting at the following edge.
- R8: A column whose `gate_en` bit is 0 is not affected by the gate. Its output is lut[{nb, own}], registered.
- R9: Columns 0, 2 and 4 are early-gate columns. Their output is lut[{nb, own & ge}], registered, where ge is `gate_out`'s source when enabled and 1 otherwise.
- R10: Columns 1, 3 and 5 are late-gate columns. Their output is lut[{nb, own}] & ge, registered.
- R11: Column i reads its table from `lut_cfg[4i+3:4i]`. Its own bit is `cmp_in[i]`. Its neighbour is `cmp_in[(i+1) mod 6]`. The table index has the neighbour as bit 1 and the own bit as bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_a | input | 1 | Write strobe for the low halves of both select fields |
| cfg_wr_b | input | 1 | Write strobe for the high halves of both select fields |
| cfg_wdata | input | 4 | Write data: [1:0] decimation half, [3:2] gate half |
| blk_out | input | 16 | Digital block output bus |
| dec_rate | input | 2 | Internal decimation rate, where nonzero suppresses the external clock |
| cmp_in | input | 6 | Column comparator bits |
| gate_en | input | 6 | Per-column gate enables |
| lut_cfg | input | 24 | Per-column 4-bit truth tables |
| dclk_out | output | 1 | Selected decimation clock |
| gate_out | output | 1 | Selected incremental gating signal |
| col_out | output | 6 | Gated column results |

## Verification
Both selectors are swept over every code. At each code the bus gets a single set bit at every position, and then all ones. The single set bit shows whether the correct line is routed, and the all-ones pattern separates valid codes from the dead codes. The columns are driven with all 64 comparator patterns and all sixteen shared truth tables, under three enable masks and both gate levels. This tells early gating apart from late gating, because the two differ only when the table maps a zero own bit to one. A pattern with a different table in each column confirms the table slice and the neighbour wiring. Single-half writes and the cycle right after a write check the register split and the latency.

// File: rtl/dgs_pkg.sv
`timescale 1ns/1ps
package dgs_pkg;
  parameter int SEL_W  = 4;
  parameter int HALF_W = SEL_W / 2;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t dsel;
    sel_t gsel;
  } sel_cfg_t;
endpackage

// File: rtl/dgs_ctl_regs.sv
`timescale 1ns/1ps
module dgs_ctl_regs
  import dgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [SEL_W-1:0]  wdata,
  output sel_cfg_t          cfg
);
  sel_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (wr_a) begin
        cfg_q.dsel[HALF_W-1:0] <= wdata[HALF_W-1:0];
        cfg_q.gsel[HALF_W-1:0] <= wdata[SEL_W-1:HALF_W];
      end
      if (wr_b) begin
        cfg_q.dsel[SEL_W-1:HALF_W] <= wdata[HALF_W-1:0];
        cfg_q.gsel[SEL_W-1:HALF_W] <= wdata[SEL_W-1:HALF_W];
      end
    end
  end

  assign cfg = cfg_q;

  // R6: fields hold when no strobe is present
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_a && !wr_b) |=> $stable(cfg_q));
  // R6: strobe a lands in the low halves only
  a_r6_low_half: assert property (@(posedge clk) disable iff (rst)
    (wr_a && !wr_b) |=> (cfg_q.dsel[HALF_W-1:0] == $past(wdata[HALF_W-1:0])
                         && $stable(cfg_q.dsel[SEL_W-1:HALF_W])));
  // R6: strobe b lands in the high halves only
  a_r6_high_half: assert property (@(posedge clk) disable iff (rst)
    (wr_b && !wr_a) |=> (cfg_q.gsel[SEL_W-1:HALF_W] == $past(wdata[SEL_W-1:HALF_W])
                         && $stable(cfg_q.gsel[HALF_W-1:0])));
endmodule

// File: rtl/dgs_sel_mux.sv
`timescale 1ns/1ps
module dgs_sel_mux #(
  parameter int N_IN    = 16,
  parameter int N_VALID = 12,
  parameter int SEL_W   = 4
) (
  input  logic [N_IN-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  localparam int N_CODES = 1 << SEL_W;

  generate
    if (N_VALID >= N_CODES) begin : g_full
      assign dout = din[sel];
    end else begin : g_partial
      assign dout = (int'(sel) < N_VALID) ? din[sel] : 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dgs_column.sv
`timescale 1ns/1ps
module dgs_column #(
  parameter bit LATE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       own,
  input  logic       nb,
  input  logic       en,
  input  logic       gate,
  input  logic [3:0] lut,
  output logic       out_q
);
  logic ge;
  logic res;

  assign ge = en ? gate : 1'b1;

  generate
    if (LATE) begin : g_late
      logic pre;
      assign pre = lut[{nb, own}];
      assign res = pre & ge;
      // R10: enabled late column with the gate low is forced low
      a_r10_forced_low: assert property (@(posedge clk) disable iff (rst)
        (en && !gate) |=> !out_q);
    end else begin : g_early
      assign res = lut[{nb, own & ge}];
      // R9: enabled early column with the gate low sees a zero own bit
      a_r9_own_zero: assert property (@(posedge clk) disable iff (rst)
        (en && !gate) |=> (out_q == $past(lut[{nb, 1'b0}])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= res;
  end

  // R8: a disabled column ignores the gate
  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_q == $past(lut[{nb, own}])));
endmodule

// File: rtl/dgs_top.sv
`timescale 1ns/1ps
module dgs_top
  import dgs_pkg::*;
#(
  parameter int          N_BLK     = 16,
  parameter int          N_DCLK    = 12,
  parameter int          N_COL     = 6,
  parameter int          RATE_W    = 2,
  parameter logic [5:0]  LATE_MASK = 6'b101010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_a,
  input  logic                cfg_wr_b,
  input  logic [SEL_W-1:0]    cfg_wdata,
  input  logic [N_BLK-1:0]    blk_out,
  input  logic [RATE_W-1:0]   dec_rate,
  input  logic [N_COL-1:0]    cmp_in,
  input  logic [N_COL-1:0]    gate_en,
  input  logic [4*N_COL-1:0]  lut_cfg,
  output logic                dclk_out,
  output logic                gate_out,
  output logic [N_COL-1:0]    col_out
);
  localparam int LUT_W = 4;

  sel_cfg_t cfg;
  logic     dclk_raw;
  logic     gate_raw;
  logic     dclk_q;
  logic     gate_q;

  dgs_ctl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_a  (cfg_wr_a),
    .wr_b  (cfg_wr_b),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  dgs_sel_mux #(.N_IN(N_BLK), .N_VALID(N_DCLK), .SEL_W(SEL_W)) u_dmux (
    .din  (blk_out),
    .sel  (cfg.dsel),
    .dout (dclk_raw)
  );

  dgs_sel_mux #(.N_IN(N_BLK), .N_VALID(N_BLK), .SEL_W(SEL_W)) u_gmux (
    .din  (blk_out),
    .sel  (cfg.gsel),
    .dout (gate_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      dclk_q <= dclk_raw & (dec_rate == '0);
      gate_q <= gate_raw;
    end
  end

  assign dclk_out = dclk_q;
  assign gate_out = gate_q;

  genvar i;
  generate
    for (i = 0; i < N_COL; i++) begin : g_col
      dgs_column #(.LATE(LATE_MASK[i])) u_col (
        .clk   (clk),
        .rst   (rst),
        .own   (cmp_in[i]),
        .nb    (cmp_in[(i + 1) % N_COL]),
        .en    (gate_en[i]),
        .gate  (gate_raw),
        .lut   (lut_cfg[LUT_W*i +: LUT_W]),
        .out_q (col_out[i])
      );
    end
  endgenerate

  // R1: outputs are cleared right after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!dclk_out && !gate_out && col_out == '0));
  // R3: dead decimation codes give a low clock
  a_r3_dead_code: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg.dsel) >= N_DCLK) |=> !dclk_out);
  // R4: a programmed rate suppresses the external clock
  a_r4_rate_mute: assert property (@(posedge clk) disable iff (rst)
    (dec_rate != '0) |=> !dclk_out);
  // R5: gate output follows the selected bus line one edge later
  a_r5_gate_route: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gate_out == $past(blk_out[cfg.gsel])));
endmodule

// File: tb/sim_dgs_top.sv
`timescale 1ns/1ps
module sim_dgs_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_a = 1'b0;
  logic        cfg_wr_b = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [15:0] blk_out = '0;
  logic [1:0]  dec_rate = '0;
  logic [5:0]  cmp_in = '0;
  logic [5:0]  gate_en = '0;
  logic [23:0] lut_cfg = '0;
  logic        dclk_out;
  logic        gate_out;
  logic [5:0]  col_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [5:0] LATE_COLS = 6'b101010;

  always #2.5 clk = ~clk;

  dgs_top u0 (
    .clk(clk), .rst(rst), .cfg_wr_a(cfg_wr_a), .cfg_wr_b(cfg_wr_b),
    .cfg_wdata(cfg_wdata), .blk_out(blk_out), .dec_rate(dec_rate),
    .cmp_in(cmp_in), .gate_en(gate_en), .lut_cfg(lut_cfg),
    .dclk_out(dclk_out), .gate_out(gate_out), .col_out(col_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_sel(input logic [3:0] d, input logic [3:0] g);
    @(negedge clk); cfg_wr_a = 1'b1; cfg_wdata = {g[1:0], d[1:0]};
    @(negedge clk); cfg_wr_a = 1'b0; cfg_wr_b = 1'b1; cfg_wdata = {g[3:2], d[3:2]};
    @(negedge clk); cfg_wr_b = 1'b0;
  endtask

  function automatic logic exp_col(input int i, input logic [5:0] c, input logic [5:0] en,
                                   input logic g, input logic [23:0] lut);
    logic own, nb, ge;
    logic [3:0] t;
    own = c[i];
    nb  = c[(i + 1) % 6];
    ge  = en[i] ? g : 1'b1;
    t   = lut[4*i +: 4];
    if (LATE_COLS[i]) return t[{nb, own}] & ge;
    else              return t[{nb, own & ge}];
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [5:0] ens [3];
    ens[0] = 6'h00; ens[1] = 6'h3F; ens[2] = 6'h15;

    // R1: outputs stay low in reset even with the inputs active
    blk_out = 16'hFFFF; cmp_in = 6'h3F; lut_cfg = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk("R1 dclk", dclk_out, 1'b0);
    chk("R1 gate", gate_out, 1'b0);
    for (int i = 0; i < 6; i++) chk("R1 col", col_out[i], 1'b0);
    rst = 1'b0; blk_out = 16'h0001; lut_cfg = '0; cmp_in = '0;
    @(negedge clk);
    // R1: select fields reset to code 0
    chk("R1 dsel0", dclk_out, 1'b1);
    chk("R1 gsel0", gate_out, 1'b1);

    // R7: the write edge still uses the old code; the next edge uses the new code
    cfg_wr_a = 1'b1; cfg_wdata = 4'b0011; blk_out = 16'h0001;
    @(negedge clk);
    chk("R7 old code", dclk_out, 1'b1);
    cfg_wr_a = 1'b0;
    @(negedge clk);
    chk("R7 new code", dclk_out, 1'b0);

    // R2 and R3: decimation select sweep
    for (int s = 0; s < 16; s++) begin
      write_sel(s[3:0], 4'd0);
      for (int k = 0; k < 16; k++) begin
        blk_out = 16'(1 << k);
        @(negedge clk);
        chk(s < 12 ? "R2" : "R3", dclk_out, (s < 12) && (k == s));
      end
      blk_out = 16'hFFFF;
      @(negedge clk);
      chk(s < 12 ? "R2 ones" : "R3 ones", dclk_out, s < 12);
    end

    // R4: rate setting mutes the decimation clock
    write_sel(4'd2, 4'd0);
    blk_out = 16'hFFFF;
    for (int r = 1; r < 4; r++) begin
      dec_rate = r[1:0];
      @(negedge clk);
      chk("R4", dclk_out, 1'b0);
    end
    dec_rate = '0;
    @(negedge clk);
    chk("R4 release", dclk_out, 1'b1);

    // R5: gate select sweep
    for (int g = 0; g < 16; g++) begin
      write_sel(4'd0, g[3:0]);
      for (int k = 0; k < 16; k++) begin
        blk_out = 16'(1 << k);
        @(negedge clk);
        chk("R5", gate_out, k == g);
      end
    end

    // R6: single-half writes
    write_sel(4'd0, 4'd0);
    @(negedge clk); cfg_wr_b = 1'b1; cfg_wdata = 4'b1110;
    @(negedge clk); cfg_wr_b = 1'b0;
    blk_out = 16'h0100; @(negedge clk);
    chk("R6 dsel=8", dclk_out, 1'b1);
    blk_out = 16'h1000; @(negedge clk);
    chk("R6 gsel=12", gate_out, 1'b1);
    @(negedge clk); cfg_wr_a = 1'b1; cfg_wdata = 4'b0101;
    @(negedge clk); cfg_wr_a = 1'b0;
    blk_out = 16'h0200; @(negedge clk);
    chk("R6 dsel=9", dclk_out, 1'b1);
    blk_out = 16'h2000; @(negedge clk);
    chk("R6 gsel=13", gate_out, 1'b1);

    // R8, R9, R10: column sweep, with the gate taken from bus line 0
    write_sel(4'd0, 4'd0);
    for (int p = 0; p < 16; p++) begin
      lut_cfg = {6{p[3:0]}};
      for (int e = 0; e < 3; e++) begin
        gate_en = ens[e];
        for (int c = 0; c < 64; c++) begin
          for (int g = 0; g < 2; g++) begin
            cmp_in = c[5:0];
            blk_out = {15'd0, g[0]};
            @(negedge clk);
            for (int i = 0; i < 6; i++)
              chk(!gate_en[i] ? "R8" : (LATE_COLS[i] ? "R10" : "R9"),
                  col_out[i], exp_col(i, cmp_in, gate_en, g[0], lut_cfg));
          end
        end
      end
    end

    // R11: a distinct table per column checks the slice and the neighbour wiring
    lut_cfg = {4'h1, 4'h2, 4'h4, 4'h8, 4'h6, 4'h9};
    gate_en = '0;
    for (int c = 0; c < 64; c++) begin
      cmp_in = c[5:0];
      @(negedge clk);
      for (int i = 0; i < 6; i++)
        chk("R11", col_out[i], exp_col(i, cmp_in, gate_en, 1'b0, lut_cfg));
    end

    done = 1;
    finish_run();
  end
endmodule